// File: doc/BRIEF.md
# Two-Step Power Mode Controller

This block decides when a small processor core may sleep and which clock domains keep running while it does. Software requests one of two sleep states, idle or power-down, by writing the power control register twice in a row. The first write sets an arm bit. The very next write to the same register sets the matching confirm bit. Only a complete pair changes the state. A stray single write never stops the clocks.

In idle, the block withholds the core clock and the watchdog clock. The oscillators and the other peripherals keep running, so any enabled peripheral interrupt can bring the core back. In power-down, both oscillator enables drop and every clock stops. Only a falling edge on the external wake pin can end this state. A latch that needs no clock captures that edge. The latched edge is then synchronized, and the oscillators are restarted. A programmable settle count runs before the core, peripherals and watchdog get their clocks again. An asynchronous reset ends either state at any moment and wins over a wake edge that arrives at the same time.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is low and right after it, `mode_o` is 00 (run), all five enables are 1 and `ctrl_rdata_o` reads 0. `mode_o` never shows 11.
- R2: Idle (`mode_o` = 01) is entered one edge after an accepted write with bit 5 set. The write accepted immediately before it must have set bit 0. Reserved bits (2, 3, 4, 7) of each accepted write read back unchanged.
- R3: A confirm bit (5 or 6) has no effect unless the previous accepted write set its arm bit. Any accepted write that is not a matching confirm replaces the pending arm bits with that write's bits 0 and 1.
- R4: In idle, `cpu_clk_en_o` = 0 and `wdt_clk_en_o` = 0, while `per_clk_en_o`, `osc_main_en_o` and `osc_aux_en_o` are 1. The readback shows bits 0 and 5 set.
- R5: Power-down (`mode_o` = 10) is entered one edge after a write with bit 6 set, when the previous write set bit 1. All five enables are then 0 and the readback shows bits 1 and 6 set.
- R6: In idle, any set bit of `irq_i` at a clock edge returns the block to run at that edge. The arm and confirm bits read 0 afterwards, and the reserved bits keep their values.
- R7: In power-down, `irq_i` has no effect. Writes to the register are ignored while the block is not in run.
- R8: A falling edge of `wake_n_i` during power-down is captured without a clock. The oscillator enables return `SYNC_STAGES`+1 edges later, while `mode_o` stays 10. The core, peripheral and watchdog enables return `wake_dly_i`+1 edges after that, with arm and confirm bits cleared. Falling edges outside power-down are ignored.
- R9: If both arm bits are pending and one write sets both confirm bits, power-down is entered.
- R10: Reset is asynchronous. It clears the pending arm bits and overrides a wake edge that occurs during reset, so no late wake sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 1 | Address matches the power control register |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | DATA_W | Write data byte |
| irq_i | input | NUM_IRQ | Enabled peripheral interrupt requests |
| wake_n_i | input | 1 | External wake pin, active low |
| wake_dly_i | input | CNT_W | Settle count after oscillator restart |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable (timers, serial, converter, interrupt logic) |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| osc_main_en_o | output | 1 | Crystal oscillator enable |
| osc_aux_en_o | output | 1 | RC oscillator enable |
| mode_o | output | 2 | State: 00 run, 01 idle, 10 power-down |
| ctrl_rdata_o | output | DATA_W | Register readback |

## Verification
Register writes and idle exits take effect on the edge that samples them. Their results are due at the falling edge that follows. A wake edge placed at a falling clock edge reaches the oscillator enables three edges later, with the default two sync stages, and reaches the core enable 4+`wake_dly_i` edges later. Each stimulus task files the expected output vector in a queue, tagged with the cycle number on which it is due. The monitor compares it only at that falling edge and flags any entry that has fallen behind. The samples taken before the due edge confirm that nothing changed early.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_IDLE = 2'd1,
      ST_PD   = 2'd2,
      ST_WARM = 2'd3
   } pmc_state_e;

   localparam logic [1:0] MODE_RUN  = 2'b00;
   localparam logic [1:0] MODE_IDLE = 2'b01;
   localparam logic [1:0] MODE_PD   = 2'b10;

   function automatic logic [1:0] mode_code(pmc_state_e st);
      case (st)
         ST_IDLE: return MODE_IDLE;
         ST_PD,
         ST_WARM: return MODE_PD;
         default: return MODE_RUN;
      endcase
   endfunction

endpackage

// File: rtl/pmc_arm_seq.sv
module pmc_arm_seq #(
   parameter int DATA_W    = 8,
   parameter int ARM_IDLE  = 0,
   parameter int CONF_IDLE = 5,
   parameter int ARM_PD    = 1,
   parameter int CONF_PD   = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_ok_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              clr_i,
   output logic              go_idle_o,
   output logic              go_pd_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [DATA_W-1:0] CTRL_MASK = (DATA_W'(1) << ARM_IDLE) |
                                             (DATA_W'(1) << CONF_IDLE) |
                                             (DATA_W'(1) << ARM_PD) |
                                             (DATA_W'(1) << CONF_PD);

   logic              pend_idle_q, pend_pd_q;
   logic              conf_idle_q, conf_pd_q;
   logic [DATA_W-1:0] rsvd_q;

   // power-down confirm wins when both are pending and both confirmed
   assign go_pd_o   = wr_ok_i && pend_pd_q && wdata_i[CONF_PD];
   assign go_idle_o = wr_ok_i && pend_idle_q && wdata_i[CONF_IDLE] && !go_pd_o;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_idle_q <= 1'b0;
         pend_pd_q   <= 1'b0;
         conf_idle_q <= 1'b0;
         conf_pd_q   <= 1'b0;
         rsvd_q      <= '0;
      end else if (clr_i) begin
         pend_idle_q <= 1'b0;
         pend_pd_q   <= 1'b0;
         conf_idle_q <= 1'b0;
         conf_pd_q   <= 1'b0;
      end else if (wr_ok_i) begin
         rsvd_q <= wdata_i & ~CTRL_MASK;
         if (go_pd_o) begin
            conf_pd_q   <= 1'b1;
            pend_idle_q <= 1'b0;
         end else if (go_idle_o) begin
            conf_idle_q <= 1'b1;
            pend_pd_q   <= 1'b0;
         end else begin
            pend_idle_q <= wdata_i[ARM_IDLE];
            pend_pd_q   <= wdata_i[ARM_PD];
         end
      end
   end

   always_comb begin
      rdata_o            = rsvd_q;
      rdata_o[ARM_IDLE]  = pend_idle_q;
      rdata_o[CONF_IDLE] = conf_idle_q;
      rdata_o[ARM_PD]    = pend_pd_q;
      rdata_o[CONF_PD]   = conf_pd_q;
   end

endmodule

// File: rtl/pmc_wake_latch.sv
module pmc_wake_latch #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_n_i,
   input  logic arm_i,
   input  logic ack_i,
   output logic wake_o
);

   logic                   flag_q;
   logic                   ack_q;
   logic                   clr_n;
   logic [SYNC_STAGES-1:0] sync_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ack_q <= 1'b0;
      else         ack_q <= ack_i;
   end

   assign clr_n = rst_ni & ~ack_q;

   // captures the pin edge while no clock runs; armed only in power-down
   always_ff @(negedge pin_n_i or negedge clr_n) begin
      if (!clr_n) flag_q <= 1'b0;
      else        flag_q <= arm_i;
   end

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     sync_q[s] <= 1'b0;
         else if (s == 0) sync_q[s] <= flag_q;
         else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
   end

   assign wake_o = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
   import pmc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             go_idle_i,
   input  logic             go_pd_i,
   input  logic             irq_any_i,
   input  logic             wake_i,
   input  logic [CNT_W-1:0] dly_i,
   output pmc_state_e       state_o,
   output logic             exit_o
);

   pmc_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_done;

   assign cnt_done = (cnt_q == '0);
   assign exit_o   = ((st_q == ST_IDLE) && irq_any_i) ||
                     ((st_q == ST_WARM) && cnt_done);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_RUN: begin
            if (go_pd_i)        st_d = ST_PD;
            else if (go_idle_i) st_d = ST_IDLE;
         end
         ST_IDLE: if (irq_any_i) st_d = ST_RUN;
         ST_PD:   if (wake_i)    st_d = ST_WARM;
         ST_WARM: if (cnt_done)  st_d = ST_RUN;
         default:                st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q  <= ST_RUN;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if ((st_q == ST_PD) && wake_i)          cnt_q <= dly_i;
         else if ((st_q == ST_WARM) && !cnt_done) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign state_o = st_q;

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pmc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int NUM_IRQ     = 4,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int ARM_IDLE    = 0,
   parameter int CONF_IDLE   = 5,
   parameter int ARM_PD      = 1,
   parameter int CONF_PD     = 6
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               reg_sel_i,
   input  logic               reg_wr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   input  logic [NUM_IRQ-1:0] irq_i,
   input  logic               wake_n_i,
   input  logic [CNT_W-1:0]   wake_dly_i,
   output logic               cpu_clk_en_o,
   output logic               per_clk_en_o,
   output logic               wdt_clk_en_o,
   output logic               osc_main_en_o,
   output logic               osc_aux_en_o,
   output logic [1:0]         mode_o,
   output logic [DATA_W-1:0]  ctrl_rdata_o
);

   localparam int CTRL_BITS = 4;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ARM_IDLE >= DATA_W || CONF_IDLE >= DATA_W ||
       ARM_PD >= DATA_W || CONF_PD >= DATA_W) begin : g_chk_pos
      $error("control bit positions exceed DATA_W");
   end
   if ($countones((1 << ARM_IDLE) | (1 << CONF_IDLE) |
                  (1 << ARM_PD) | (1 << CONF_PD)) != CTRL_BITS) begin : g_chk_dist
      $error("control bit positions must be distinct");
   end
   if (NUM_IRQ < 1 || CNT_W < 1) begin : g_chk_size
      $error("NUM_IRQ and CNT_W must be positive");
   end

   pmc_state_e state;
   logic       wr_ok, go_idle, go_pd, exit_evt, wake_sync;

   assign wr_ok = reg_sel_i && reg_wr_i && (state == ST_RUN);

   pmc_arm_seq #(
      .DATA_W   (DATA_W),
      .ARM_IDLE (ARM_IDLE),
      .CONF_IDLE(CONF_IDLE),
      .ARM_PD   (ARM_PD),
      .CONF_PD  (CONF_PD)
   ) u_arm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_ok_i  (wr_ok),
      .wdata_i  (reg_wdata_i),
      .clr_i    (exit_evt),
      .go_idle_o(go_idle),
      .go_pd_o  (go_pd),
      .rdata_o  (ctrl_rdata_o)
   );

   pmc_wake_latch #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_wake (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_n_i(wake_n_i),
      .arm_i  (state == ST_PD),
      .ack_i  (state == ST_WARM),
      .wake_o (wake_sync)
   );

   pmc_fsm #(
      .CNT_W(CNT_W)
   ) u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .go_idle_i(go_idle),
      .go_pd_i  (go_pd),
      .irq_any_i(|irq_i),
      .wake_i   (wake_sync),
      .dly_i    (wake_dly_i),
      .state_o  (state),
      .exit_o   (exit_evt)
   );

   always_comb begin
      mode_o = mode_code(state);
      unique case (state)
         ST_IDLE: {osc_main_en_o, osc_aux_en_o, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o} = 5'b11010;
         ST_PD:   {osc_main_en_o, osc_aux_en_o, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o} = 5'b00000;
         ST_WARM: {osc_main_en_o, osc_aux_en_o, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o} = 5'b11000;
         default: {osc_main_en_o, osc_aux_en_o, cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o} = 5'b11111;
      endcase
   end

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
   parameter int DATA_W    = 8,
   parameter int NUM_IRQ   = 4,
   parameter int ARM_IDLE  = 0,
   parameter int CONF_IDLE = 5,
   parameter int ARM_PD    = 1,
   parameter int CONF_PD   = 6
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               reg_sel_i,
   input logic               reg_wr_i,
   input logic [DATA_W-1:0]  reg_wdata_i,
   input logic [NUM_IRQ-1:0] irq_i,
   input logic               cpu_clk_en_o,
   input logic               per_clk_en_o,
   input logic               wdt_clk_en_o,
   input logic               osc_main_en_o,
   input logic               osc_aux_en_o,
   input logic [1:0]         mode_o,
   input logic [DATA_W-1:0]  ctrl_rdata_o
);

   logic ctrl_zero;
   assign ctrl_zero = !ctrl_rdata_o[ARM_IDLE] && !ctrl_rdata_o[CONF_IDLE] &&
                      !ctrl_rdata_o[ARM_PD] && !ctrl_rdata_o[CONF_PD];

   AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_o != 2'b11);  // R1

   AST_IDLE_NEEDS_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b01 && $past(mode_o) == 2'b00) |->
      $past(reg_sel_i && reg_wr_i && reg_wdata_i[CONF_IDLE]));  // R2

   AST_IDLE_GATING: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b01) |-> (!cpu_clk_en_o && !wdt_clk_en_o && per_clk_en_o &&
                             osc_main_en_o && osc_aux_en_o));  // R4

   AST_PD_NEEDS_CONFIRM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10 && $past(mode_o) == 2'b00) |->
      $past(reg_sel_i && reg_wr_i && reg_wdata_i[CONF_PD]));  // R5

   AST_PD_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !osc_main_en_o |-> (!cpu_clk_en_o && !per_clk_en_o && !wdt_clk_en_o));  // R5

   AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b01 && (|irq_i)) |=> (mode_o == 2'b00));  // R6

   AST_EXIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b00 && $past(mode_o) != 2'b00) |-> ctrl_zero);  // R6

   AST_PD_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'b10 && !osc_main_en_o) |=> (mode_o == 2'b10));  // R7

   AST_CPU_AFTER_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cpu_clk_en_o) |-> $past(osc_main_en_o));  // R8

endmodule

bind pwr_mode_ctrl pmc_checker #(
   .DATA_W   (DATA_W),
   .NUM_IRQ  (NUM_IRQ),
   .ARM_IDLE (ARM_IDLE),
   .CONF_IDLE(CONF_IDLE),
   .ARM_PD   (ARM_PD),
   .CONF_PD  (CONF_PD)
) u_pmc_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .reg_sel_i    (reg_sel_i),
   .reg_wr_i     (reg_wr_i),
   .reg_wdata_i  (reg_wdata_i),
   .irq_i        (irq_i),
   .cpu_clk_en_o (cpu_clk_en_o),
   .per_clk_en_o (per_clk_en_o),
   .wdt_clk_en_o (wdt_clk_en_o),
   .osc_main_en_o(osc_main_en_o),
   .osc_aux_en_o (osc_aux_en_o),
   .mode_o       (mode_o),
   .ctrl_rdata_o (ctrl_rdata_o)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;

   localparam int K_RUN = 0, K_IDLE = 1, K_PD = 2, K_WARM = 3;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       reg_sel_i = 1'b0, reg_wr_i = 1'b0;
   logic [7:0] reg_wdata_i = '0;
   logic [3:0] irq_i = '0;
   logic       wake_n_i = 1'b1;
   logic [7:0] wake_dly_i = 8'd3;
   logic       cpu_clk_en_o, per_clk_en_o, wdt_clk_en_o, osc_main_en_o, osc_aux_en_o;
   logic [1:0] mode_o;
   logic [7:0] ctrl_rdata_o;

   pwr_mode_ctrl dut (.*);

   always #2 clk_i = ~clk_i;  // 250 MHz

   typedef struct {
      int          due;
      logic [14:0] exp;
      string       tag;
   } sb_item_t;

   sb_item_t sb[$];
   int cyc = 0, checks = 0, errors = 0;
   bit done = 0;

   always @(posedge clk_i) cyc <= cyc + 1;

   function automatic logic [14:0] ev(int k, logic [7:0] c);
      case (k)
         K_IDLE:  return {2'b01, 5'b11010, c};
         K_PD:    return {2'b10, 5'b00000, c};
         K_WARM:  return {2'b10, 5'b11000, c};
         default: return {2'b00, 5'b11111, c};
      endcase
   endfunction

   task automatic expect_at(int d, int k, logic [7:0] c, string tag);
      sb_item_t it;
      it.due = cyc + d;
      it.exp = ev(k, c);
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compare each queued item at the falling edge on which it is due
   always @(negedge clk_i) begin
      logic [14:0] obs;
      obs = {mode_o, osc_main_en_o, osc_aux_en_o, cpu_clk_en_o, per_clk_en_o,
             wdt_clk_en_o, ctrl_rdata_o};
      while (sb.size() > 0 && sb[0].due <= cyc) begin
         sb_item_t it;
         it = sb.pop_front();
         checks++;
         if (it.due != cyc || obs !== it.exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d, due %0d)",
                     it.tag, obs, it.exp, cyc, it.due);
         end
      end
   end

   task automatic wr(logic [7:0] d);
      @(negedge clk_i);
      reg_sel_i = 1'b1; reg_wr_i = 1'b1; reg_wdata_i = d;
      @(negedge clk_i);
      reg_sel_i = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
   endtask

   task automatic pulse_wake();
      wake_n_i = 1'b0;
      #1 wake_n_i = 1'b1;
   endtask

   task automatic do_reset();
      @(negedge clk_i); rst_ni = 1'b0;
      @(negedge clk_i); @(negedge clk_i); rst_ni = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk_i);
      expect_at(1, K_RUN, 8'h00, "R1 reset state");
      @(negedge clk_i); rst_ni = 1'b1;
      expect_at(1, K_RUN, 8'h00, "R1 after reset release");
      @(negedge clk_i);

      // idle entry, with reserved bit 7 kept
      wr(8'h81); expect_at(1, K_RUN, 8'h81, "R3 arm idle pending");
      wr(8'hA0); expect_at(1, K_IDLE, 8'hA1, "R2 idle entry");
      expect_at(2, K_IDLE, 8'hA1, "R4 idle gating");
      wr(8'h00); expect_at(1, K_IDLE, 8'hA1, "R7 write ignored in idle");
      @(negedge clk_i);
      expect_at(1, K_IDLE, 8'hA1, "R6 no irq stays idle");
      @(negedge clk_i);
      irq_i = 4'b0100;
      expect_at(1, K_RUN, 8'h80, "R6 irq wake, reserved kept");
      @(negedge clk_i); irq_i = '0;
      @(negedge clk_i);

      // confirm without arm, and cancelled arm
      wr(8'h20); expect_at(1, K_RUN, 8'h00, "R3 confirm alone");
      wr(8'h01); expect_at(1, K_RUN, 8'h01, "R3 arm again");
      wr(8'h10); expect_at(1, K_RUN, 8'h10, "R3 other write cancels");
      wr(8'h20); expect_at(1, K_RUN, 8'h00, "R3 late confirm");
      wr(8'h02); wr(8'h20); expect_at(1, K_RUN, 8'h00, "R3 wrong confirm");

      // wake edge outside power-down is dropped
      @(negedge clk_i); pulse_wake();
      wr(8'h02); expect_at(1, K_RUN, 8'h02, "R3 arm pd pending");
      wr(8'h40); expect_at(1, K_PD, 8'h42, "R5 power-down entry");
      @(negedge clk_i);
      irq_i = 4'hF;
      expect_at(1, K_PD, 8'h42, "R7 irq ignored in pd");
      expect_at(4, K_PD, 8'h42, "R8 stale pin edge ignored");
      repeat (5) @(negedge clk_i);
      irq_i = '0;
      wr(8'h01); expect_at(1, K_PD, 8'h42, "R7 write ignored in pd");

      // wake with settle count 3
      @(negedge clk_i);
      pulse_wake();
      expect_at(2, K_PD, 8'h42, "R8 still asleep while syncing");
      expect_at(3, K_WARM, 8'h42, "R8 oscillators restart");
      expect_at(6, K_WARM, 8'h42, "R8 settle in progress");
      expect_at(7, K_RUN, 8'h00, "R8 core released");
      repeat (9) @(negedge clk_i);

      // both armed, both confirmed, zero settle count
      wake_dly_i = 8'd0;
      wr(8'h03); expect_at(1, K_RUN, 8'h03, "R9 both armed");
      wr(8'h60); expect_at(1, K_PD, 8'h42, "R9 pd wins");
      @(negedge clk_i);
      pulse_wake();
      expect_at(3, K_WARM, 8'h42, "R8 zero delay warm");
      expect_at(4, K_RUN, 8'h00, "R8 zero delay release");
      repeat (6) @(negedge clk_i);

      // reset during power-down together with wake edge
      wake_dly_i = 8'd3;
      wr(8'h02); wr(8'h40); expect_at(1, K_PD, 8'h42, "R5 pd again");
      @(negedge clk_i);
      rst_ni = 1'b0;
      pulse_wake();
      expect_at(1, K_RUN, 8'h00, "R10 reset exits pd");
      @(negedge clk_i); @(negedge clk_i);
      rst_ni = 1'b1;
      expect_at(5, K_RUN, 8'h00, "R10 no late wake");
      repeat (7) @(negedge clk_i);

      // reset clears a pending arm
      wr(8'h01); expect_at(1, K_RUN, 8'h01, "R10 arm before reset");
      @(negedge clk_i);
      do_reset();
      wr(8'h20); expect_at(1, K_RUN, 8'h00, "R10 arm cleared by reset");

      repeat (4) @(negedge clk_i);
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule